// File: doc/BRIEF.md
# Cache Range Maintenance Sequencer

This block turns one request for cache upkeep over a byte range into a stream of per-line commands for a cache controller. A request carries a half-open range `[start, end)` and a kind: invalidate, clean or flush. The sequencer walks the range one 32-byte line at a time. For each line it emits clean and/or invalidate commands through a valid/ready channel. It closes every request with a barrier command and then pulses `done` for one cycle.

An invalidate that only partly covers its first or last line does not discard that line outright. The line is cleaned first, so bytes outside the range reach memory before the line is dropped. Lines that the range covers completely are only invalidated.

An invalidate or flush that spans the whole address space (start 0, end all ones) is not walked line by line. It is handed to a separate whole-cache sweep engine through a request/acknowledge pair, and the barrier follows once the sweep is acknowledged.

Top module: `cmaint_seq`

## Requirements
- R1: Every clean or invalidate command carries a line address whose low 5 bits are zero. Command opcodes are clean = 0, invalidate = 1 and barrier = 2.
- R2: A clean request (kind 1) aligns start down to a line boundary. It then emits exactly one clean per line below end, in ascending address order.
- R3: A flush request (kind 2) aligns start down to a line boundary. For each line below end it emits a clean, then an invalidate to the same address, in ascending order.
- R4: An invalidate request (kind 0) whose start is not line aligned emits a clean, then an invalidate, for the line that holds start.
- R5: In an invalidate request, each line lying wholly inside the range receives one invalidate and no clean.
- R6: In an invalidate request whose end is not line aligned, the line that holds end receives a clean, then an invalidate. If that line also holds an unaligned start, it is served once.
- R7: An invalidate or flush request with start = 0 and end = 0xFFFFFFFF emits no line commands. It raises `sweep_req` with `sweep_kind` (0 = invalidate, 1 = flush) and holds it until `sweep_ack`.
- R8: Each request ends with exactly one barrier command, placed after all of its line commands. `done` is high for the single cycle that follows acceptance of that barrier.
- R9: A request with start >= end emits only the barrier, followed by `done`.
- R10: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, `cmd_op` and `cmd_addr` hold their values.
- R11: `req_ready` is high only when the sequencer is idle. A request presented while it is busy is ignored and does not change the command stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request accepted on this cycle if valid |
| req_kind | input | 2 | 0 invalidate, 1 clean, 2 flush |
| req_start | input | 32 | First byte address of the range |
| req_end | input | 32 | Byte address just past the range |
| cmd_valid | output | 1 | Command present |
| cmd_ready | input | 1 | Controller takes the command |
| cmd_op | output | 2 | 0 clean, 1 invalidate, 2 barrier |
| cmd_addr | output | 32 | Line address (zero for barrier) |
| sweep_req | output | 1 | Whole-cache sweep requested |
| sweep_kind | output | 1 | 0 invalidate sweep, 1 flush sweep |
| sweep_ack | input | 1 | Sweep engine finished |
| done | output | 1 | One-cycle pulse after the barrier is taken |

## Verification
The hardest case to reach is an invalidate whose partial first line, full middle lines and partial last line all fall in one request. The difficulty grows when the controller stalls while the sequencer is between the clean and the invalidate of the same line. The directed cases place start and end at unaligned offsets. They drive `cmd_ready` in a repeating stall pattern, so stalls land on both sub-steps of a line. The collected stream is compared with a list that the bench builds from the range rules. A second request is also injected while the sequencer is busy, to show that it is ignored.

// File: rtl/cmaint_pkg.sv
package cmaint_pkg;

  typedef enum logic [1:0] {
    KIND_INV   = 2'd0,
    KIND_CLEAN = 2'd1,
    KIND_FLUSH = 2'd2
  } req_kind_e;

  typedef enum logic [1:0] {
    CMD_CLEAN   = 2'd0,
    CMD_INV     = 2'd1,
    CMD_BARRIER = 2'd2
  } cmd_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SWEEP,
    ST_LINE,
    ST_BAR,
    ST_DRAIN
  } seq_state_e;

endpackage

// File: rtl/cmaint_line_plan.sv
// Decides, for the line under the cursor, which command comes next.
module cmaint_line_plan
  import cmaint_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 5
) (
  input  logic [1:0]      kind,
  input  logic [ADDR_W:0] cursor,
  input  logic [ADDR_W-1:0] rng_start,
  input  logic [ADDR_W-1:0] rng_end,
  input  logic            second_step,
  output logic            in_range,
  output logic [1:0]      emit_op,
  output logic            step_last
);

  localparam logic [ADDR_W-1:0] LINE_MASK = {{(ADDR_W-OFS_W){1'b1}}, {OFS_W{1'b0}}};

  logic head_partial, tail_partial, edge_line;
  logic want_clean, want_inv;

  always_comb begin
    in_range     = cursor < {1'b0, rng_end};
    head_partial = (cursor[ADDR_W-1:0] == (rng_start & LINE_MASK)) &&
                   (rng_start[OFS_W-1:0] != '0);
    tail_partial = (cursor[ADDR_W-1:0] == (rng_end & LINE_MASK)) &&
                   (rng_end[OFS_W-1:0] != '0);
    edge_line    = (kind == KIND_INV) && (head_partial || tail_partial);
    want_clean   = (kind == KIND_CLEAN) || (kind == KIND_FLUSH) || edge_line;
    want_inv     = (kind == KIND_INV) || (kind == KIND_FLUSH);
    if (!second_step && want_clean) begin
      emit_op   = CMD_CLEAN;
      step_last = !want_inv;
    end else begin
      emit_op   = CMD_INV;
      step_last = 1'b1;
    end
  end

endmodule

// File: rtl/cmaint_cmd_slot.sv
// Registered command output with valid/ready hold.
module cmaint_cmd_slot #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [1:0]        load_op,
  input  logic [ADDR_W-1:0] load_addr,
  output logic              free,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [1:0]        cmd_op,
  output logic [ADDR_W-1:0] cmd_addr
);

  assign free = !cmd_valid || cmd_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_valid <= 1'b0;
      cmd_op    <= '0;
      cmd_addr  <= '0;
    end else if (load && free) begin
      cmd_valid <= 1'b1;
      cmd_op    <= load_op;
      cmd_addr  <= load_addr;
    end else if (cmd_ready) begin
      cmd_valid <= 1'b0;
    end
  end

  p_hold_stable_r10: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) && $stable(cmd_addr))
    else $error("R10: command changed under backpressure");

endmodule

// File: rtl/cmaint_seq.sv
module cmaint_seq
  import cmaint_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_start,
  input  logic [ADDR_W-1:0] req_end,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [1:0]        cmd_op,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              sweep_req,
  output logic              sweep_kind,
  input  logic              sweep_ack,
  output logic              done
);

  localparam int OFS_W = $clog2(LINE_BYTES);
  localparam logic [ADDR_W-1:0] LINE_MASK = {{(ADDR_W-OFS_W){1'b1}}, {OFS_W{1'b0}}};
  localparam logic [ADDR_W:0]   LINE_STEP = (ADDR_W+1)'(LINE_BYTES);

  seq_state_e        state;
  logic [1:0]        kind_q;
  logic [ADDR_W-1:0] start_q, end_q;
  logic [ADDR_W:0]   cur_q;
  logic              phase_q;

  logic              in_range, step_last, slot_free, slot_load;
  logic [1:0]        plan_op, load_op;
  logic [ADDR_W-1:0] load_addr;
  logic              whole_space;

  cmaint_line_plan #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_plan (
    .kind(kind_q), .cursor(cur_q), .rng_start(start_q), .rng_end(end_q),
    .second_step(phase_q), .in_range(in_range), .emit_op(plan_op),
    .step_last(step_last)
  );

  always_comb begin
    slot_load = 1'b0;
    load_op   = CMD_BARRIER;
    load_addr = '0;
    if (state == ST_LINE && in_range) begin
      slot_load = 1'b1;
      load_op   = plan_op;
      load_addr = cur_q[ADDR_W-1:0];
    end else if (state == ST_BAR) begin
      slot_load = 1'b1;
    end
  end

  cmaint_cmd_slot #(.ADDR_W(ADDR_W)) u_slot (
    .clk(clk), .rst(rst), .load(slot_load), .load_op(load_op),
    .load_addr(load_addr), .free(slot_free), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_addr(cmd_addr)
  );

  assign req_ready   = (state == ST_IDLE);
  assign whole_space = (req_kind != KIND_CLEAN) && (req_start == '0) && (&req_end);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      kind_q     <= '0;
      start_q    <= '0;
      end_q      <= '0;
      cur_q      <= '0;
      phase_q    <= 1'b0;
      sweep_req  <= 1'b0;
      sweep_kind <= 1'b0;
      done       <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (req_valid) begin
          kind_q  <= req_kind;
          start_q <= req_start;
          end_q   <= req_end;
          cur_q   <= {1'b0, req_start & LINE_MASK};
          phase_q <= 1'b0;
          if (whole_space) begin
            sweep_req  <= 1'b1;
            sweep_kind <= (req_kind == KIND_FLUSH);
            state      <= ST_SWEEP;
          end else if (req_start >= req_end) begin
            state <= ST_BAR;
          end else begin
            state <= ST_LINE;
          end
        end
        ST_SWEEP: if (sweep_ack) begin
          sweep_req <= 1'b0;
          state     <= ST_BAR;
        end
        ST_LINE: begin
          if (!in_range) begin
            state <= ST_BAR;
          end else if (slot_free) begin
            if (step_last) begin
              cur_q   <= cur_q + LINE_STEP;
              phase_q <= 1'b0;
            end else begin
              phase_q <= 1'b1;
            end
          end
        end
        ST_BAR: if (slot_free) state <= ST_DRAIN;
        ST_DRAIN: if (cmd_valid && cmd_ready) begin
          done  <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_line_aligned_r1: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_op != CMD_BARRIER |-> cmd_addr[OFS_W-1:0] == '0)
    else $error("R1: unaligned line command");

  p_sweep_hold_r7: assert property (@(posedge clk) disable iff (rst)
    sweep_req && !sweep_ack |=> sweep_req)
    else $error("R7: sweep request dropped before ack");

  p_sweep_no_cmd_r7: assert property (@(posedge clk) disable iff (rst)
    sweep_req |-> !cmd_valid)
    else $error("R7: line command during sweep");

  p_done_after_barrier_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(cmd_valid && cmd_ready && cmd_op == CMD_BARRIER))
    else $error("R8: done without barrier acceptance");

  p_ready_idle_r11: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !cmd_valid && !sweep_req)
    else $error("R11: ready while work is pending");

endmodule

// File: tb/test_cmaint_seq.sv
module test_cmaint_seq;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_kind = '0;
  logic [31:0] req_start = '0, req_end = '0;
  logic        cmd_valid;
  logic        cmd_ready = 1'b0;
  logic [1:0]  cmd_op;
  logic [31:0] cmd_addr;
  logic        sweep_req, sweep_kind;
  logic        sweep_ack = 1'b0;
  logic        done;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  cmaint_seq i_cmaint_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_start(req_start), .req_end(req_end),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .sweep_req(sweep_req), .sweep_kind(sweep_kind),
    .sweep_ack(sweep_ack), .done(done)
  );

  int          exp_n, got_n;
  logic [1:0]  exp_op [0:255];
  logic [31:0] exp_addr [0:255];
  logic [1:0]  got_op [0:255];
  logic [31:0] got_addr [0:255];

  task automatic chk(bit ok, string tag, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  task automatic push(logic [1:0] op, logic [31:0] a);
    exp_op[exp_n] = op;
    exp_addr[exp_n] = a;
    exp_n++;
  endtask

  // Expected stream built from the range rules.
  task automatic build_exp(logic [1:0] kind, logic [31:0] s, logic [31:0] e);
    longint cur, last_full;
    exp_n = 0;
    if (s < e) begin
      cur = s;
      if (kind == 2'd0) begin
        if (s[4:0] != 0) begin
          push(2'd0, {s[31:5], 5'd0});
          push(2'd1, {s[31:5], 5'd0});
          cur = (cur | 31) + 1;
        end
        last_full = longint'({e[31:5], 5'd0});
        while (cur < last_full) begin
          push(2'd1, 32'(cur));
          cur += 32;
        end
        if (cur < longint'(e)) begin
          push(2'd0, 32'(cur));
          push(2'd1, 32'(cur));
        end
      end else begin
        cur = longint'({s[31:5], 5'd0});
        while (cur < longint'(e)) begin
          push(2'd0, 32'(cur));
          if (kind == 2'd2) push(2'd1, 32'(cur));
          cur += 32;
        end
      end
    end
    push(2'd2, 32'd0);
  endtask

  task automatic run_case(string tag, logic [1:0] kind, logic [31:0] s,
                          logic [31:0] e, bit bp, bit busy);
    bit   sweep_exp, sweep_seen, kind_seen, prev_hold, hold_ok, align_ok;
    int   bar_cyc, done_cyc, wait_cnt, cyc;
    logic [1:0]  prev_op;
    logic [31:0] prev_addr;
    sweep_exp = (kind != 2'd1) && s == 0 && e == 32'hFFFF_FFFF;
    if (sweep_exp) begin
      exp_n = 0;
      push(2'd2, 32'd0);
    end else build_exp(kind, s, e);
    got_n = 0; sweep_seen = 0; kind_seen = 0; hold_ok = 1; align_ok = 1;
    prev_hold = 0; bar_cyc = -1; done_cyc = -1; wait_cnt = 0;
    @(negedge clk);
    chk(req_ready, "R11", "ready when idle", req_ready, 1);
    req_valid = 1; req_kind = kind; req_start = s; req_end = e;
    @(negedge clk);
    req_valid = 0;
    for (cyc = 0; cyc < 3000 && done_cyc < 0; cyc++) begin
      if (cyc > 0) @(negedge clk);
      cmd_ready = bp ? (cyc % 3 != 1) : 1'b1;
      if (sweep_req) begin
        sweep_seen = 1;
        kind_seen = sweep_kind;
        wait_cnt++;
      end
      sweep_ack = sweep_req && wait_cnt > 3;
      if (busy && cyc == 2) begin
        chk(!req_ready, "R11", "ready while busy", req_ready, 0);
        req_valid = 1; req_kind = 2'd1; req_start = 32'h0; req_end = 32'h100;
      end else req_valid = 0;
      #1;
      if (prev_hold && !(cmd_valid && cmd_op == prev_op && cmd_addr == prev_addr))
        hold_ok = 0;
      if (cmd_valid && cmd_op != 2'd2 && cmd_addr[4:0] != 0) align_ok = 0;
      if (done) done_cyc = cyc;
      if (cmd_valid && cmd_ready && got_n < 256) begin
        got_op[got_n] = cmd_op;
        got_addr[got_n] = cmd_addr;
        if (cmd_op == 2'd2) bar_cyc = cyc;
        got_n++;
      end
      prev_hold = cmd_valid && !cmd_ready;
      prev_op = cmd_op;
      prev_addr = cmd_addr;
    end
    req_valid = 0; sweep_ack = 0; cmd_ready = 0;
    chk(done_cyc >= 0, tag, "done seen", done_cyc, 0);
    chk(got_n == exp_n, tag, "command count", got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n; i++)
      chk(got_op[i] == exp_op[i] && got_addr[i] == exp_addr[i], tag,
          $sformatf("cmd %0d op/addr", i), {got_op[i], got_addr[i]},
          {exp_op[i], exp_addr[i]});
    chk(got_n > 0 && got_op[got_n-1] == 2'd2, "R8", "barrier last",
        got_n > 0 ? got_op[got_n-1] : 3, 2);
    chk(done_cyc == bar_cyc + 1, "R8", "done one cycle after barrier",
        done_cyc, bar_cyc + 1);
    chk(align_ok, "R1", "line address alignment", align_ok, 1);
    chk(sweep_seen == sweep_exp, "R7", "sweep requested", sweep_seen, sweep_exp);
    if (sweep_exp)
      chk(kind_seen == (kind == 2'd2), "R7", "sweep kind", kind_seen, kind == 2'd2);
    if (bp) chk(hold_ok, "R10", "hold under stall", hold_ok, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!cmd_valid && req_ready && !done && !sweep_req, "R11", "reset state",
        {cmd_valid, req_ready, done, sweep_req}, 4'b0100);
    run_case("R2", 2'd1, 32'h0000_1004, 32'h0000_1071, 0, 0);
    run_case("R3", 2'd2, 32'h0000_0200, 32'h0000_0260, 1, 1);
    run_case("R4", 2'd0, 32'h0000_010C, 32'h0000_01A9, 1, 0);
    run_case("R5", 2'd0, 32'h0000_0400, 32'h0000_0480, 0, 1);
    run_case("R6", 2'd0, 32'h0000_0021, 32'h0000_002F, 1, 0);
    run_case("R6", 2'd0, 32'h0000_0040, 32'h0000_00A5, 0, 0);
    run_case("R9", 2'd0, 32'h0000_0085, 32'h0000_0085, 0, 0);
    run_case("R9", 2'd2, 32'h0000_0090, 32'h0000_0010, 0, 0);
    run_case("R7", 2'd0, 32'h0000_0000, 32'hFFFF_FFFF, 0, 0);
    run_case("R7", 2'd2, 32'h0000_0000, 32'hFFFF_FFFF, 1, 0);
    run_case("R2", 2'd1, 32'hFFFF_FFC0, 32'hFFFF_FFFF, 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule